// File: doc/BRIEF.md
# I2C Target Address Match and Event Logic

This block is the byte-level target (slave) side of an I2C controller. A bit-level front end, which is not part of this block, reports bus activity as single-cycle events: a START, a completed byte, or a STOP. The block compares each address byte against up to four programmable 7-bit addresses, each with its own enable. It acknowledges only matching addresses. For write transactions it queues every received byte with a tag that marks the address byte, the middle data bytes, or the final byte before the stop.

For read transactions it raises a read event and holds the clock low. It keeps the clock low until the host loads a transmit byte and sets the start/busy flag. A stretch timer, counted in prescaled ticks, bounds that wait. When the timer expires, the clock is released and a timeout code is recorded. Every event is latched in a write-one-to-clear status register, and an interrupt output reports the enabled status bits.

The host reaches the block through a simple indexed register port. Reads are combinational, and a read of the receive index pops one queue entry.

Top module: `i2c_tgt_event`

## Requirements
- R1: After reset, index 5 (status) and index 3 (command) read 0; bus_ack, scl_hold, tgt_tx_valid and irq are low; and a read of index 7 returns tag 0.
- R2: Address slot k sits in bits 8k+6..8k of index 0, with its enable at bit 8k+7. The event kinds on bus_evt_kind are 0 START, 1 byte and 2 STOP. For a byte event in the address phase, bus_ack pulses in the next cycle only when bus_byte[7:1] equals an enabled slot. Otherwise nothing in that transaction is acknowledged or queued until the next START.
- R3: In a write transaction, index 7 returns entries with a tag in bits 31:30 and the byte in bits 7:0. Tag 1 marks the address byte, tag 2 a data byte, and tag 3 the last data byte before a STOP or a repeated START. Tag 0 means the queue is empty.
- R4: Status bit 24 is set by every entry that is queued. Status bit 25 is set when a push brings the count to at least the threshold in index 2 bits 13:8, provided that threshold is nonzero. Index 2 bits 22:16 show the entry count.
- R5: Status bit 26 is set when a push finds the queue full or fills it. Entries that arrive while the queue is full are lost.
- R6: A matching address with bit 0 set raises status bit 21 and holds scl_hold high. The hold lasts until a byte has been written to index 6 and index 3 bit 31 (busy) has been set. The block then drives tgt_tx_valid with that byte on tgt_tx_byte and releases scl_hold.
- R7: A byte event while tgt_tx_valid is high has the following effects:
  - busy clears, the result in index 3 bits 25:23 becomes 0, and status bit 23 is set;
  - with bus_byte[0]=1 (the reader acknowledged), status bit 22 is also set and scl_hold returns;
  - with bus_byte[0]=0, the read ends without a hold.
- R8: While scl_hold is high, a timer counts ticks of DIV_SLOW cycles, or of DIV_FAST cycles when index 1 bit 31 is set. After the number of ticks in index 1 bits 30:24, the timer releases the hold, clears busy, sets the result to 5 and sets status bit 23. A limit of 0 never expires.
- R9: Status bits 26:21 at index 5 are write-one-to-clear. A hardware set in the same cycle as a clear keeps the bit. irq is high exactly when some status bit and its enable in index 4 bits 26:21 are both set.
- R10: In one write transaction, data bytes beyond MAX_XFER are neither acknowledged nor queued.
- R11: Writing index 2 bit 31 empties the receive queue. Writing index 2 bit 30 discards a loaded transmit byte, so the clock hold continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_evt_valid | input | 1 | A bus event is present this cycle |
| bus_evt_kind | input | 2 | 0 START, 1 byte, 2 STOP |
| bus_byte | input | 8 | Received byte, or the reader's acknowledge in bit 0 during a read |
| bus_ack | output | 1 | Acknowledge for the byte event of the previous cycle |
| scl_hold | output | 1 | Hold the clock low (stretch) |
| tgt_tx_valid | output | 1 | A transmit byte is ready for the front end |
| tgt_tx_byte | output | 8 | Transmit byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at index 7) |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions can occur in the same cycle. The first is a host write-one-to-clear of the status register arriving with a byte event that queues an entry and so sets the receive-event bit. The bench drives both strobes on one clock edge and then expects bit 24 to remain set while the other cleared bits stay cleared. The second is a stretch-timer expiry racing the host's busy set. It is judged by reading the result code and the hold output in windows a few cycles before and after the computed expiry.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
   typedef enum logic [1:0] {EV_START = 2'd0, EV_BYTE = 2'd1, EV_STOP = 2'd2} bus_ev_e;
   typedef enum logic [1:0] {TAG_NONE = 2'd0, TAG_FIRST = 2'd1, TAG_MID = 2'd2, TAG_LAST = 2'd3} rx_tag_e;
   typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_WRITE, ST_READ, ST_SKIP} tgt_state_e;

   // status bit positions, relative to STAT_LSB
   localparam int STAT_LSB = 21;
   localparam int STAT_W   = 6;
   localparam int S_RDEV   = 0;
   localparam int S_TXUND  = 1;
   localparam int S_DONE   = 2;
   localparam int S_RXEV   = 3;
   localparam int S_RXTHR  = 4;
   localparam int S_RXFULL = 5;

   localparam logic [2:0] RES_OK      = 3'd0;
   localparam logic [2:0] RES_TIMEOUT = 3'd5;

   localparam logic [2:0] RI_ADDR = 3'd0;
   localparam logic [2:0] RI_TIME = 3'd1;
   localparam logic [2:0] RI_FIFO = 3'd2;
   localparam logic [2:0] RI_CMD  = 3'd3;
   localparam logic [2:0] RI_IEN  = 3'd4;
   localparam logic [2:0] RI_IST  = 3'd5;
   localparam logic [2:0] RI_TX   = 3'd6;
   localparam logic [2:0] RI_RX   = 3'd7;
endpackage

// File: rtl/i2c_tgt_addr_match.sv
`timescale 1ns/1ps
module i2c_tgt_addr_match #(
   parameter int N_SLOTS = 4
) (
   input  logic [N_SLOTS*8-1:0] cfg,
   input  logic [6:0]           addr,
   output logic                 hit
);
   localparam int SLOT_W = 8;
   logic [N_SLOTS-1:0] slot_hit;

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      assign slot_hit[g] = cfg[g*SLOT_W + SLOT_W - 1] && (cfg[g*SLOT_W +: 7] == addr);
   end

   assign hit = |slot_hit;
endmodule

// File: rtl/i2c_tgt_rxq.sv
`timescale 1ns/1ps
module i2c_tgt_rxq #(
   parameter int DEPTH = 64,
   parameter int W     = 10,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("rx queue depth must be a power of two of at least 2");
   end

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/i2c_tgt_stretch.sv
`timescale 1ns/1ps
module i2c_tgt_stretch #(
   parameter int LIMIT_W  = 7,
   parameter int DIV_SLOW = 8,
   parameter int DIV_FAST = 2,
   localparam int DMAX    = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST,
   localparam int PW      = $clog2(DMAX) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               fast,
   input  logic [LIMIT_W-1:0] limit,
   output logic               expire
);
   logic [PW-1:0]      pre;
   logic [PW-1:0]      div_m1;
   logic [LIMIT_W-1:0] ticks;
   logic               tick;

   if (DIV_SLOW < 1 || DIV_FAST < 1) begin : g_bad_div
      $error("stretch prescale divisors must be at least 1");
   end

   assign div_m1 = fast ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
   assign tick   = run && (pre == div_m1);
   assign expire = tick && (limit != '0) && (ticks == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre   <= '0;
         ticks <= '0;
      end else if (!run) begin
         pre   <= '0;
         ticks <= '0;
      end else if (tick) begin
         pre   <= '0;
         ticks <= ticks + 1'b1;
      end else begin
         pre   <= pre + 1'b1;
      end
   end
endmodule

// File: rtl/i2c_tgt_event.sv
`timescale 1ns/1ps
module i2c_tgt_event
   import i2c_tgt_pkg::*;
#(
   parameter int N_SLOTS  = 4,
   parameter int RX_DEPTH = 64,
   parameter int MAX_XFER = 64,
   parameter int LIMIT_W  = 7,
   parameter int THR_W    = 6,
   parameter int DIV_SLOW = 8,
   parameter int DIV_FAST = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_evt_valid,
   input  logic [1:0]  bus_evt_kind,
   input  logic [7:0]  bus_byte,
   output logic        bus_ack,
   output logic        scl_hold,
   output logic        tgt_tx_valid,
   output logic [7:0]  tgt_tx_byte,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_idx,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq
);
   localparam int CW      = $clog2(RX_DEPTH) + 1;
   localparam int XW      = $clog2(MAX_XFER + 1);
   localparam int ENTRY_W = 10;

   if (N_SLOTS < 1 || N_SLOTS > 4) begin : g_bad_slots
      $error("N_SLOTS must be 1 to 4");
   end
   if (RX_DEPTH > 64 || LIMIT_W > 7 || THR_W > 6 || MAX_XFER < 1) begin : g_bad_field
      $error("parameter does not fit its register field");
   end

   // configuration and host-visible state
   logic [31:0]         addr_cfg;
   logic [LIMIT_W-1:0]  stretch_lim;
   logic                fast_mode;
   logic [THR_W-1:0]    thr;
   logic                busy;
   logic [2:0]          result;
   logic [STAT_W-1:0]   ien, ists, st_set, st_clr;
   logic [7:0]          tx_data;
   logic                tx_v;

   // transaction state
   tgt_state_e          state;
   logic [7:0]          pend_byte;
   logic                pend_v;
   logic [XW-1:0]       xfer_cnt;

   // decoded events
   logic ev_start, ev_byte, ev_stop, hit, room, tx_ok, byte_sent, expire;
   logic push;
   logic [ENTRY_W-1:0] push_entry;
   logic [ENTRY_W-1:0] q_rdata;
   logic [CW-1:0]      q_count;
   logic               q_empty, q_full, q_pop, rx_flush;
   logic [7:0]         cnt_after, thr8;

   assign ev_start  = bus_evt_valid && (bus_evt_kind == EV_START);
   assign ev_byte   = bus_evt_valid && (bus_evt_kind == EV_BYTE);
   assign ev_stop   = bus_evt_valid && (bus_evt_kind == EV_STOP);
   assign room      = (xfer_cnt < XW'(MAX_XFER));
   assign tx_ok     = (state == ST_READ) && busy && tx_v;
   assign byte_sent = ev_byte && tx_ok;

   assign scl_hold     = (state == ST_READ) && !tx_ok;
   assign tgt_tx_valid = tx_ok;
   assign tgt_tx_byte  = tx_data;

   i2c_tgt_addr_match #(.N_SLOTS(N_SLOTS)) u_match (
      .cfg  (addr_cfg[N_SLOTS*8-1:0]),
      .addr (bus_byte[7:1]),
      .hit  (hit)
   );

   i2c_tgt_stretch #(.LIMIT_W(LIMIT_W), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_stretch (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (scl_hold),
      .fast   (fast_mode),
      .limit  (stretch_lim),
      .expire (expire)
   );

   assign q_pop    = reg_rd && (reg_idx == RI_RX);
   assign rx_flush = reg_wr && (reg_idx == RI_FIFO) && reg_wdata[31];

   i2c_tgt_rxq #(.DEPTH(RX_DEPTH), .W(ENTRY_W)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (rx_flush),
      .push  (push),
      .wdata (push_entry),
      .pop   (q_pop),
      .rdata (q_rdata),
      .count (q_count),
      .empty (q_empty),
      .full  (q_full)
   );

   // queue push selection and status set sources
   assign cnt_after = 8'(q_count) + 8'd1;
   assign thr8      = 8'(thr);

   always_comb begin
      push       = 1'b0;
      push_entry = '0;
      st_set     = '0;
      if ((ev_start || ev_stop) && state == ST_WRITE && pend_v) begin
         push       = 1'b1;
         push_entry = {TAG_LAST, pend_byte};
      end else if (ev_byte && state == ST_ADDR && hit && !bus_byte[0]) begin
         push       = 1'b1;
         push_entry = {TAG_FIRST, bus_byte};
      end else if (ev_byte && state == ST_WRITE && room && pend_v) begin
         push       = 1'b1;
         push_entry = {TAG_MID, pend_byte};
      end
      if (push && !q_full) begin
         st_set[S_RXEV] = 1'b1;
         if (thr != '0 && cnt_after >= thr8) st_set[S_RXTHR] = 1'b1;
      end
      if (push && (q_full || q_count == CW'(RX_DEPTH - 1))) st_set[S_RXFULL] = 1'b1;
      if (ev_byte && state == ST_ADDR && hit && bus_byte[0]) st_set[S_RDEV] = 1'b1;
      if (byte_sent) begin
         st_set[S_DONE] = 1'b1;
         if (bus_byte[0]) st_set[S_TXUND] = 1'b1;
      end
      if (expire) st_set[S_DONE] = 1'b1;
   end

   assign st_clr = (reg_wr && reg_idx == RI_IST) ? reg_wdata[STAT_LSB +: STAT_W] : '0;
   assign irq    = |(ists & ien);

   // transaction state machine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pend_byte <= '0;
         pend_v    <= 1'b0;
         xfer_cnt  <= '0;
         bus_ack   <= 1'b0;
      end else begin
         bus_ack <= ev_byte && ((state == ST_ADDR && hit) || (state == ST_WRITE && room));
         if (expire) state <= ST_SKIP;
         if (ev_start) begin
            state    <= ST_ADDR;
            pend_v   <= 1'b0;
            xfer_cnt <= '0;
         end else if (ev_stop) begin
            state  <= ST_IDLE;
            pend_v <= 1'b0;
         end else if (ev_byte) begin
            case (state)
               ST_ADDR: begin
                  if (!hit)             state <= ST_SKIP;
                  else if (bus_byte[0]) state <= ST_READ;
                  else                  state <= ST_WRITE;
               end
               ST_WRITE: begin
                  if (room) begin
                     xfer_cnt  <= xfer_cnt + 1'b1;
                     pend_byte <= bus_byte;
                     pend_v    <= 1'b1;
                  end
               end
               ST_READ: begin
                  if (tx_ok && !bus_byte[0]) state <= ST_SKIP;
               end
               default: ;
            endcase
         end
      end
   end

   // host registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_cfg    <= '0;
         stretch_lim <= '0;
         fast_mode   <= 1'b0;
         thr         <= '0;
         busy        <= 1'b0;
         result      <= RES_OK;
         ien         <= '0;
         ists        <= '0;
         tx_data     <= '0;
         tx_v        <= 1'b0;
      end else begin
         ists <= (ists & ~st_clr) | st_set;
         if (expire) begin
            busy   <= 1'b0;
            result <= RES_TIMEOUT;
         end else if (byte_sent) begin
            busy   <= 1'b0;
            result <= RES_OK;
         end
         if (byte_sent) tx_v <= 1'b0;
         if (reg_wr) begin
            case (reg_idx)
               RI_ADDR: addr_cfg <= reg_wdata;
               RI_TIME: begin
                  stretch_lim <= reg_wdata[24 +: LIMIT_W];
                  fast_mode   <= reg_wdata[31];
               end
               RI_FIFO: begin
                  thr <= reg_wdata[8 +: THR_W];
                  if (reg_wdata[30]) tx_v <= 1'b0;
               end
               RI_CMD:  if (reg_wdata[31]) busy <= 1'b1;
               RI_IEN:  ien <= reg_wdata[STAT_LSB +: STAT_W];
               RI_TX: begin
                  tx_data <= reg_wdata[7:0];
                  tx_v    <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // combinational read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_idx)
         RI_ADDR: reg_rdata = addr_cfg;
         RI_TIME: begin
            reg_rdata[31]           = fast_mode;
            reg_rdata[24 +: LIMIT_W] = stretch_lim;
         end
         RI_FIFO: begin
            reg_rdata[16 +: CW]    = q_count;
            reg_rdata[8 +: THR_W]  = thr;
         end
         RI_CMD: begin
            reg_rdata[31]    = busy;
            reg_rdata[25:23] = result;
         end
         RI_IEN:  reg_rdata[STAT_LSB +: STAT_W] = ien;
         RI_IST:  reg_rdata[STAT_LSB +: STAT_W] = ists;
         RI_TX: begin
            reg_rdata[31]  = tx_v;
            reg_rdata[7:0] = tx_data;
         end
         RI_RX: begin
            if (!q_empty) begin
               reg_rdata[31:30] = q_rdata[9:8];
               reg_rdata[7:0]   = q_rdata[7:0];
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/i2c_tgt_event_chk.sv
`timescale 1ns/1ps
module i2c_tgt_event_chk #(
   parameter int RX_DEPTH = 64,
   localparam int CW      = $clog2(RX_DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_evt_valid,
   input logic [1:0]    bus_evt_kind,
   input logic [7:0]    bus_byte,
   input logic          bus_ack,
   input logic          scl_hold,
   input logic          tgt_tx_valid,
   input logic          irq,
   input logic [5:0]    ien,
   input logic [CW-1:0] q_count
);
   // R2
   ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |-> $past(bus_evt_valid && bus_evt_kind == 2'd1));

   // R6
   hold_excl_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold |-> !tgt_tx_valid);

   // R7
   tx_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_tx_valid && bus_evt_valid && bus_evt_kind == 2'd1) |=> !tgt_tx_valid);

   // R7
   reader_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_tx_valid && bus_evt_valid && bus_evt_kind == 2'd1 && bus_byte[0]) |=> scl_hold);

   // R5
   rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(RX_DEPTH));

   // R9
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0 && $past(ien) == '0) |-> !irq);
endmodule

bind i2c_tgt_event i2c_tgt_event_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_evt_valid (bus_evt_valid),
   .bus_evt_kind  (bus_evt_kind),
   .bus_byte      (bus_byte),
   .bus_ack       (bus_ack),
   .scl_hold      (scl_hold),
   .tgt_tx_valid  (tgt_tx_valid),
   .irq           (irq),
   .ien           (ien),
   .q_count       (q_count)
);

// File: tb/test_i2c_tgt_event.sv
`timescale 1ns/1ps
module test_i2c_tgt_event;
   localparam int DEPTH = 16;
   localparam int MAXX  = 8;
   localparam int DSLOW = 8;
   localparam int DFAST = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_evt_valid = 1'b0;
   logic [1:0]  bus_evt_kind = 2'd0;
   logic [7:0]  bus_byte = 8'd0;
   logic        bus_ack, scl_hold, tgt_tx_valid, irq;
   logic [7:0]  tgt_tx_byte;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_idx = 3'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   logic [9:0] mq[$];
   bit last_ack;

   always #2.5 clk = ~clk;

   i2c_tgt_event #(.RX_DEPTH(DEPTH), .MAX_XFER(MAXX), .DIV_SLOW(DSLOW), .DIV_FAST(DFAST)) i_i2c_tgt_event (
      .clk(clk), .rst_n(rst_n), .bus_evt_valid(bus_evt_valid), .bus_evt_kind(bus_evt_kind),
      .bus_byte(bus_byte), .bus_ack(bus_ack), .scl_hold(scl_hold), .tgt_tx_valid(tgt_tx_valid),
      .tgt_tx_byte(tgt_tx_byte), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ev(input logic [1:0] k, input logic [7:0] b);
      @(negedge clk);
      bus_evt_valid = 1'b1; bus_evt_kind = k; bus_byte = b;
      @(negedge clk);
      bus_evt_valid = 1'b0;
      last_ack = bus_ack;
   endtask

   task automatic wr(input logic [2:0] i, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] i, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_idx = i;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   function automatic bit exp_match(input logic [6:0] a);
      return (a == 7'h2A) || (a == 7'h51) || (a == 7'h7F);
   endfunction

   function automatic void mpush(input logic [9:0] e);
      if (mq.size() < DEPTH) mq.push_back(e);
   endfunction

   task automatic do_write(input logic [6:0] a, input int n);
      logic [7:0] prev;
      logic [7:0] b;
      bit pv;
      bit m;
      pv = 0;
      prev = 8'd0;
      m = exp_match(a);
      ev(2'd0, 8'd0);
      ev(2'd1, {a, 1'b0});
      chk(last_ack == m, "R2 address ack", 32'(last_ack), 32'(m));
      if (m) mpush({2'd1, a, 1'b0});
      for (int i = 0; i < n; i++) begin
         b = 8'($urandom);
         ev(2'd1, b);
         chk(last_ack == (m && i < MAXX), "R10 data ack", 32'(last_ack), 32'(m && i < MAXX));
         if (m && i < MAXX) begin
            if (pv) mpush({2'd2, prev});
            prev = b;
            pv = 1;
         end
      end
      ev(2'd2, 8'd0);
      if (pv) mpush({2'd3, prev});
   endtask

   task automatic drain();
      logic [31:0] d;
      logic [9:0] e;
      while (mq.size() > 0) begin
         e = mq.pop_front();
         rd(3'd7, d);
         chk({d[31:30], d[7:0]} == e, "R3 queue entry", {22'd0, d[31:30], d[7:0]}, {22'd0, e});
      end
      rd(3'd7, d);
      chk(d[31:30] == 2'd0, "R3 empty tag", d, 32'd0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [6:0] a;
      int sel;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!bus_ack && !scl_hold && !tgt_tx_valid && !irq, "R1 outputs low",
          {bus_ack, scl_hold, tgt_tx_valid, irq}, 0);
      rd(3'd5, d); chk(d == 0, "R1 status", d, 0);
      rd(3'd3, d); chk(d == 0, "R1 command", d, 0);
      rd(3'd7, d); chk(d[31:30] == 0, "R1 empty pop", d, 0);

      // slots: 0x2A on, 0x51 on, 0x33 off, 0x7F on
      wr(3'd0, {1'b1, 7'h7F, 1'b0, 7'h33, 1'b1, 7'h51, 1'b1, 7'h2A});

      // R2 R3 R10 random write transactions
      for (int it = 0; it < 30; it++) begin
         sel = $urandom_range(0, 4);
         case (sel)
            0: a = 7'h2A;
            1: a = 7'h51;
            2: a = 7'h33;
            3: a = 7'h7F;
            default: a = 7'($urandom);
         endcase
         do_write(a, $urandom_range(0, MAXX + 2));
         drain();
      end

      // R10 directed: ten bytes, two rejected
      do_write(7'h2A, 10);
      rd(3'd2, d); chk(d[22:16] == 7'(MAXX + 1), "R10 count", d[22:16], MAXX + 1);
      drain();
      // R2 disabled slot ignored
      do_write(7'h33, 3);
      rd(3'd2, d); chk(d[22:16] == 0, "R2 disabled slot not queued", d[22:16], 0);

      // R5 queue full
      wr(3'd5, 32'hFFFF_FFFF);
      do_write(7'h51, 5); do_write(7'h51, 5); do_write(7'h51, 5);
      rd(3'd5, d); chk(d[26] == 1'b1, "R5 full bit", d, 32'h0400_0000);
      rd(3'd2, d); chk(d[22:16] == DEPTH, "R5 count at depth", d[22:16], DEPTH);
      drain();

      // R4 threshold and receive event
      wr(3'd2, 32'd3 << 8);
      wr(3'd5, 32'hFFFF_FFFF);
      do_write(7'h2A, 1);
      rd(3'd5, d); chk(d[25:24] == 2'b01, "R4 below threshold", d[26:21], 6'h08);
      do_write(7'h2A, 1);
      rd(3'd5, d); chk(d[25:24] == 2'b11, "R4 threshold reached", d[26:21], 6'h18);
      drain();
      wr(3'd2, 32'd0);

      // R9 same-cycle set and clear
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd4, 32'h0100_0000);
      ev(2'd0, 0); ev(2'd1, {7'h2A, 1'b0});
      chk(irq == 1'b1, "R9 irq on enabled bit", irq, 1);
      ev(2'd1, 8'h11);
      @(negedge clk);
      reg_wr = 1'b1; reg_idx = 3'd5; reg_wdata = 32'hFFFF_FFFF;
      bus_evt_valid = 1'b1; bus_evt_kind = 2'd1; bus_byte = 8'h22;
      @(negedge clk);
      reg_wr = 1'b0; bus_evt_valid = 1'b0;
      rd(3'd5, d); chk(d[26:21] == 6'h08, "R9 set wins over clear", d[26:21], 6'h08);
      wr(3'd5, 32'h0100_0000);
      #1 chk(irq == 1'b0, "R9 irq cleared", irq, 0);
      ev(2'd2, 0);
      wr(3'd4, 32'd0);
      mq.delete();
      mq.push_back({2'd1, 8'h54}); mq.push_back({2'd2, 8'h11}); mq.push_back({2'd3, 8'h22});
      drain();

      // R6 R7 read flow
      wr(3'd5, 32'hFFFF_FFFF);
      ev(2'd0, 0); ev(2'd1, {7'h51, 1'b1});
      chk(last_ack == 1'b1, "R6 read address ack", last_ack, 1);
      chk(scl_hold == 1'b1, "R6 hold while empty", scl_hold, 1);
      rd(3'd5, d); chk(d[21] == 1'b1, "R6 read event", d[26:21], 6'h01);
      wr(3'd6, 32'hA5);
      chk(scl_hold == 1'b1 && !tgt_tx_valid, "R6 hold until busy", scl_hold, 1);
      wr(3'd3, 32'h8000_0000);
      chk(tgt_tx_valid && !scl_hold && tgt_tx_byte == 8'hA5, "R6 byte presented", tgt_tx_byte, 8'hA5);
      wr(3'd5, 32'hFFFF_FFFF);
      ev(2'd1, 8'h01);
      chk(scl_hold && !tgt_tx_valid, "R7 hold after reader ack", scl_hold, 1);
      rd(3'd5, d); chk(d[23:22] == 2'b11, "R7 done and underrun", d[26:21], 6'h06);
      rd(3'd3, d); chk(d[31] == 0 && d[25:23] == 0, "R7 busy clear ok result", d, 0);
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'h3C); wr(3'd3, 32'h8000_0000);
      chk(tgt_tx_byte == 8'h3C && tgt_tx_valid, "R7 second byte", tgt_tx_byte, 8'h3C);
      ev(2'd1, 8'h00);
      chk(!scl_hold && !tgt_tx_valid, "R7 reader nack ends", scl_hold, 0);
      rd(3'd5, d); chk(d[23:22] == 2'b10, "R7 no underrun on nack", d[26:21], 6'h04);
      ev(2'd2, 0);

      // R8 stretch timeout, slow then fast
      wr(3'd1, 32'd5 << 24);
      wr(3'd5, 32'hFFFF_FFFF);
      ev(2'd0, 0); ev(2'd1, {7'h7F, 1'b1});
      repeat (5 * DSLOW - 3) @(negedge clk);
      chk(scl_hold == 1'b1, "R8 still holding slow", scl_hold, 1);
      repeat (6) @(negedge clk);
      chk(scl_hold == 1'b0, "R8 released slow", scl_hold, 0);
      rd(3'd3, d); chk(d[25:23] == 3'd5 && d[31] == 0, "R8 timeout result", d, 32'h0280_0000);
      rd(3'd5, d); chk(d[23] == 1'b1, "R8 done bit", d[26:21], 6'h04);
      ev(2'd2, 0);
      wr(3'd1, 32'h8000_0000 | (32'd5 << 24));
      ev(2'd0, 0); ev(2'd1, {7'h2A, 1'b1});
      repeat (5 * DFAST - 3) @(negedge clk);
      chk(scl_hold == 1'b1, "R8 still holding fast", scl_hold, 1);
      repeat (6) @(negedge clk);
      chk(scl_hold == 1'b0, "R8 released fast", scl_hold, 0);
      ev(2'd2, 0);
      wr(3'd1, 32'd0);

      // R11 flushes
      do_write(7'h51, 3);
      wr(3'd2, 32'h8000_0000);
      mq.delete();
      rd(3'd2, d); chk(d[22:16] == 0, "R11 rx flush count", d[22:16], 0);
      rd(3'd7, d); chk(d[31:30] == 0, "R11 rx flush empty", d, 0);
      ev(2'd0, 0); ev(2'd1, {7'h51, 1'b1});
      wr(3'd6, 32'h77);
      wr(3'd2, 32'h4000_0000);
      wr(3'd3, 32'h8000_0000);
      chk(scl_hold && !tgt_tx_valid, "R11 tx flush keeps hold", scl_hold, 1);
      ev(2'd2, 0);

      finish_run();
   end
endmodule